// File: doc/BRIEF.md
# Paged Network Controller Register File

This block is the register file a host processor sees when it programs a simple Ethernet controller. It sits on a byte-wide bus with a 4-bit address. Address 0 holds a command register that can be reached from any bank. Every other address is banked by the top two command bits. The block keeps the receive ring limits, the transmit and remote-DMA setup, the station address and the multicast filter mask, and drives all of them out to the packet-moving logic.

It also keeps an interrupt status register and an interrupt mask, and drives one level-sensitive interrupt line. The receive engine and the DMA engine report completion through single-cycle event inputs. A command write can start a transmit, which raises a one-cycle request to the transmit engine, or finish a remote transfer of length zero at once. Read data is combinational from the address and the current bank.

Top module: `netctl_regfile`

## Requirements
- R1: After reset the interrupt status reads 0x80, the command reads 0x00, the interrupt line and the transmit request are low, and every setup output is zero.
- R2: Address 0 reads and writes the command register in every bank. Any other address selects effective index {command[7:6], address}, so the same address reaches different registers in bank 0 and bank 1.
- R3: Bank 0 writes store these registers, each driven on its output port: 1 ring start, 2 ring stop, 3 boundary, 4 transmit page, 5/6 transmit count low/high, 8/9 remote address low/high, A/B remote count low/high, E data configuration, F interrupt mask. A write to one byte half of a 16-bit value leaves the other half unchanged.
- R4: Bank 0 reads return the boundary at 3, the transmit status at 4, the interrupt status at 7 and the remote address low/high at 8/9. Every other bank 0 offset reads 0x00, including write-only offsets such as 1.
- R5: In bank 1, offsets 1 to 6 are station bytes 0 to 5 (byte k on station_addr[8k+7:8k]), offset 7 is the current receive page, and offsets 8 to F are mask bytes 0 to 7 (byte k on mcast_mask[8k+7:8k]). All of them can be both read and written.
- R6: In banks 2 and 3, writes to addresses 1 to F change nothing, and reads return 0x00.
- R7: Writing the interrupt status clears each of bits 0 to 6 that is 1 in the written value. Bit 7 (reset indication) is never cleared by this write.
- R8: The interrupt line is high exactly when interrupt status AND mask is nonzero. It follows in the cycle after the status or the mask changes.
- R9: A command write with bit 1 (start) set clears status bit 7.
- R10: A command write with start and either bit 3 (remote read) or bit 4 (remote write) sets status bit 6 when the remote count is zero. It does not set bit 6 when the count is nonzero.
- R11: A command write with start and bit 2 (transmit) set raises tx_req for exactly one cycle, sets the transmit status to 0x01 and sets status bit 1. With bit 2 set but start clear, none of this happens.
- R12: A pulse on rx_done sets status bit 0 and a pulse on dma_done sets status bit 6 at the next clock edge. When a host clear targets the same bit in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Host register address |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr in the current bank |
| rx_done | input | 1 | Receive-complete event pulse |
| dma_done | input | 1 | Remote-DMA-complete event pulse |
| irq | output | 1 | Level interrupt request |
| tx_req | output | 1 | One-cycle transmit start request |
| ring_start | output | 8 | Receive ring first page |
| ring_stop | output | 8 | Receive ring end page |
| boundary | output | 8 | Ring boundary page |
| tx_page | output | 8 | Transmit buffer start page |
| tx_count | output | 16 | Transmit byte count |
| rdma_addr | output | 16 | Remote DMA start address |
| rdma_count | output | 16 | Remote DMA byte count |
| data_cfg | output | 8 | Data configuration byte |
| cur_page | output | 8 | Current receive page |
| station_addr | output | 48 | Station address, byte 0 in the low bits |
| mcast_mask | output | 64 | Multicast filter mask, byte 0 in the low bits |

## Verification
The hardest case to reach from the ports is a host clear of the interrupt status and a completion event that land on the same bit in the same clock cycle. The bench drives the clear write and the dma_done pulse on one falling edge, so both are sampled by the same rising edge. It then reads the status back to confirm that the event bit survived while the other low bits were cleared. The zero-length remote transfer is reached by loading a remote count, checking that a start command does not complete it, then loading zero and issuing the command again.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
   localparam int ADDR_W = 4;
   localparam int PAGE_W = 2;
   localparam int IDX_W  = ADDR_W + PAGE_W;
   localparam int BYTE_W = 8;
   localparam int N_IDX  = 2 ** IDX_W;

   // bank 0 effective indices
   localparam logic [IDX_W-1:0] IX_RSTART = 6'h01;
   localparam logic [IDX_W-1:0] IX_RSTOP  = 6'h02;
   localparam logic [IDX_W-1:0] IX_BNDRY  = 6'h03;
   localparam logic [IDX_W-1:0] IX_TXPG   = 6'h04;
   localparam logic [IDX_W-1:0] IX_TXSTAT = 6'h04;
   localparam logic [IDX_W-1:0] IX_TXCL   = 6'h05;
   localparam logic [IDX_W-1:0] IX_TXCH   = 6'h06;
   localparam logic [IDX_W-1:0] IX_ISR    = 6'h07;
   localparam logic [IDX_W-1:0] IX_RAL    = 6'h08;
   localparam logic [IDX_W-1:0] IX_RAH    = 6'h09;
   localparam logic [IDX_W-1:0] IX_RCL    = 6'h0A;
   localparam logic [IDX_W-1:0] IX_RCH    = 6'h0B;
   localparam logic [IDX_W-1:0] IX_DCFG   = 6'h0E;
   localparam logic [IDX_W-1:0] IX_IMR    = 6'h0F;
   localparam int               BANK1_BASE = 16;

   // command bits
   localparam int CMD_START = 1;
   localparam int CMD_TX    = 2;
   localparam int CMD_RRD   = 3;
   localparam int CMD_RWR   = 4;

   // interrupt status bits
   localparam int IS_RX  = 0;
   localparam int IS_TX  = 1;
   localparam int IS_DMA = 6;
   localparam int IS_RST = 7;

   localparam logic [BYTE_W-1:0] ISR_RESET_VAL = 8'h80;
   localparam logic [BYTE_W-1:0] TSR_DONE_VAL  = 8'h01;
endpackage

// File: rtl/netctl_decode.sv
module netctl_decode
   import netctl_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [PAGE_W-1:0] page,
   output logic [IDX_W-1:0]  idx,
   output logic              cmd_wr,
   output logic [N_IDX-1:0]  wr_hit
);
   assign idx    = {page, addr};
   assign cmd_wr = wr && (addr == '0);

   generate
      for (genvar i = 0; i < N_IDX; i++) begin : g_hit
         assign wr_hit[i] = wr && (addr != '0) && (idx == IDX_W'(i));
      end
   endgenerate
endmodule

// File: rtl/netctl_setup_regs.sv
module netctl_setup_regs
   import netctl_pkg::*;
#(
   parameter int N_STA   = 6,
   parameter int N_MC    = 8,
   parameter int IX_STA0 = BANK1_BASE + 1,
   parameter int IX_CUR  = BANK1_BASE + 1 + N_STA,
   parameter int IX_MC0  = BANK1_BASE + 2 + N_STA
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_IDX-1:0]         wr_hit,
   input  logic [BYTE_W-1:0]        wdata,
   output logic [BYTE_W-1:0]        ring_start,
   output logic [BYTE_W-1:0]        ring_stop,
   output logic [BYTE_W-1:0]        boundary,
   output logic [BYTE_W-1:0]        tx_page,
   output logic [2*BYTE_W-1:0]      tx_count,
   output logic [2*BYTE_W-1:0]      rdma_addr,
   output logic [2*BYTE_W-1:0]      rdma_count,
   output logic [BYTE_W-1:0]        data_cfg,
   output logic [BYTE_W-1:0]        cur_page,
   output logic [N_STA*BYTE_W-1:0]  station_addr,
   output logic [N_MC*BYTE_W-1:0]   mcast_mask
);
   logic unused_hits;
   assign unused_hits = ^wr_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_start   <= '0;
         ring_stop    <= '0;
         boundary     <= '0;
         tx_page      <= '0;
         tx_count     <= '0;
         rdma_addr    <= '0;
         rdma_count   <= '0;
         data_cfg     <= '0;
         cur_page     <= '0;
         station_addr <= '0;
         mcast_mask   <= '0;
      end else begin
         if (wr_hit[IX_RSTART]) ring_start <= wdata;
         if (wr_hit[IX_RSTOP])  ring_stop  <= wdata;
         if (wr_hit[IX_BNDRY])  boundary   <= wdata;
         if (wr_hit[IX_TXPG])   tx_page    <= wdata;
         if (wr_hit[IX_TXCL])   tx_count[BYTE_W-1:0]        <= wdata;
         if (wr_hit[IX_TXCH])   tx_count[2*BYTE_W-1:BYTE_W] <= wdata;
         if (wr_hit[IX_RAL])    rdma_addr[BYTE_W-1:0]        <= wdata;
         if (wr_hit[IX_RAH])    rdma_addr[2*BYTE_W-1:BYTE_W] <= wdata;
         if (wr_hit[IX_RCL])    rdma_count[BYTE_W-1:0]        <= wdata;
         if (wr_hit[IX_RCH])    rdma_count[2*BYTE_W-1:BYTE_W] <= wdata;
         if (wr_hit[IX_DCFG])   data_cfg   <= wdata;
         if (wr_hit[IX_CUR])    cur_page   <= wdata;
         for (int k = 0; k < N_STA; k++)
            if (wr_hit[IX_STA0 + k]) station_addr[k*BYTE_W +: BYTE_W] <= wdata;
         for (int k = 0; k < N_MC; k++)
            if (wr_hit[IX_MC0 + k]) mcast_mask[k*BYTE_W +: BYTE_W] <= wdata;
      end
   end
endmodule

// File: rtl/netctl_cmd_status.sv
module netctl_cmd_status
   import netctl_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_wr,
   input  logic                isr_wr,
   input  logic                imr_wr,
   input  logic [BYTE_W-1:0]   wdata,
   input  logic [2*BYTE_W-1:0] rdma_count,
   input  logic                rx_done,
   input  logic                dma_done,
   output logic [BYTE_W-1:0]   cmd_q,
   output logic [BYTE_W-1:0]   isr_q,
   output logic [BYTE_W-1:0]   imr_q,
   output logic [BYTE_W-1:0]   tsr_q,
   output logic                tx_req,
   output logic                irq
);
   logic              start_w;
   logic              tx_go;
   logic [BYTE_W-1:0] isr_d;

   assign start_w = cmd_wr && wdata[CMD_START];
   assign tx_go   = start_w && wdata[CMD_TX];

   always_comb begin
      isr_d = isr_q;
      if (isr_wr) isr_d[IS_RST-1:0] = isr_q[IS_RST-1:0] & ~wdata[IS_RST-1:0];
      if (start_w) begin
         isr_d[IS_RST] = 1'b0;
         if ((wdata[CMD_RRD] || wdata[CMD_RWR]) && (rdma_count == '0))
            isr_d[IS_DMA] = 1'b1;
         if (wdata[CMD_TX]) isr_d[IS_TX] = 1'b1;
      end
      if (rx_done)  isr_d[IS_RX]  = 1'b1;
      if (dma_done) isr_d[IS_DMA] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         isr_q  <= ISR_RESET_VAL;
         imr_q  <= '0;
         tsr_q  <= '0;
         tx_req <= 1'b0;
      end else begin
         if (cmd_wr) cmd_q <= wdata;
         if (imr_wr) imr_q <= wdata;
         if (tx_go)  tsr_q <= TSR_DONE_VAL;
         isr_q  <= isr_d;
         tx_req <= tx_go;
      end
   end

   assign irq = |(isr_q & imr_q);
endmodule

// File: rtl/netctl_regfile.sv
module netctl_regfile
   import netctl_pkg::*;
#(
   parameter int N_STA = 6,
   parameter int N_MC  = 8
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [3:0]              host_addr,
   input  logic                    host_wr,
   input  logic [7:0]              host_wdata,
   output logic [7:0]              host_rdata,
   input  logic                    rx_done,
   input  logic                    dma_done,
   output logic                    irq,
   output logic                    tx_req,
   output logic [7:0]              ring_start,
   output logic [7:0]              ring_stop,
   output logic [7:0]              boundary,
   output logic [7:0]              tx_page,
   output logic [15:0]             tx_count,
   output logic [15:0]             rdma_addr,
   output logic [15:0]             rdma_count,
   output logic [7:0]              data_cfg,
   output logic [7:0]              cur_page,
   output logic [N_STA*8-1:0]      station_addr,
   output logic [N_MC*8-1:0]       mcast_mask
);
   localparam int IX_STA0 = BANK1_BASE + 1;
   localparam int IX_CUR  = IX_STA0 + N_STA;
   localparam int IX_MC0  = IX_CUR + 1;

   generate
      if (N_STA < 1 || N_MC < 1 || IX_MC0 + N_MC != 2 * BANK1_BASE) begin : g_bad_layout
         $error("netctl_regfile: bank 1 must hold N_STA + N_MC + 1 = 15 bytes");
      end
      if (BYTE_W != 8 || ADDR_W != 4) begin : g_bad_bus
         $error("netctl_regfile: bus must be 8 bits wide with 4 address bits");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic              cmd_wr;
   logic [N_IDX-1:0]  wr_hit;
   logic [7:0]        cmd_q;
   logic [7:0]        isr_q;
   logic [7:0]        imr_q;
   logic [7:0]        tsr_q;

   netctl_decode u_decode (
      .addr   (host_addr),
      .wr     (host_wr),
      .page   (cmd_q[7:8-PAGE_W]),
      .idx    (idx),
      .cmd_wr (cmd_wr),
      .wr_hit (wr_hit)
   );

   netctl_setup_regs #(
      .N_STA   (N_STA),
      .N_MC    (N_MC),
      .IX_STA0 (IX_STA0),
      .IX_CUR  (IX_CUR),
      .IX_MC0  (IX_MC0)
   ) u_setup (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_hit       (wr_hit),
      .wdata        (host_wdata),
      .ring_start   (ring_start),
      .ring_stop    (ring_stop),
      .boundary     (boundary),
      .tx_page      (tx_page),
      .tx_count     (tx_count),
      .rdma_addr    (rdma_addr),
      .rdma_count   (rdma_count),
      .data_cfg     (data_cfg),
      .cur_page     (cur_page),
      .station_addr (station_addr),
      .mcast_mask   (mcast_mask)
   );

   netctl_cmd_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .isr_wr     (wr_hit[IX_ISR]),
      .imr_wr     (wr_hit[IX_IMR]),
      .wdata      (host_wdata),
      .rdma_count (rdma_count),
      .rx_done    (rx_done),
      .dma_done   (dma_done),
      .cmd_q      (cmd_q),
      .isr_q      (isr_q),
      .imr_q      (imr_q),
      .tsr_q      (tsr_q),
      .tx_req     (tx_req),
      .irq        (irq)
   );

   // read-side decode differs from the write side at offset 4 and elsewhere
   always_comb begin
      host_rdata = '0;
      if (host_addr == '0) begin
         host_rdata = cmd_q;
      end else begin
         case (idx)
            IX_BNDRY:  host_rdata = boundary;
            IX_TXSTAT: host_rdata = tsr_q;
            IX_ISR:    host_rdata = isr_q;
            IX_RAL:    host_rdata = rdma_addr[7:0];
            IX_RAH:    host_rdata = rdma_addr[15:8];
            default:   host_rdata = '0;
         endcase
         if (idx == IDX_W'(IX_CUR)) host_rdata = cur_page;
         for (int k = 0; k < N_STA; k++)
            if (idx == IDX_W'(IX_STA0 + k)) host_rdata = station_addr[k*8 +: 8];
         for (int k = 0; k < N_MC; k++)
            if (idx == IDX_W'(IX_MC0 + k)) host_rdata = mcast_mask[k*8 +: 8];
      end
   end
endmodule

// File: rtl/netctl_regfile_chk.sv
module netctl_regfile_chk #(
   parameter int STA_W = 48,
   parameter int MC_W  = 64
)(
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       host_addr,
   input logic             host_wr,
   input logic [7:0]       host_wdata,
   input logic             rx_done,
   input logic             dma_done,
   input logic             irq,
   input logic             tx_req,
   input logic [7:0]       cmd_q,
   input logic [7:0]       isr_q,
   input logic [7:0]       imr_q,
   input logic [7:0]       tsr_q,
   input logic [7:0]       ring_start,
   input logic [15:0]      tx_count,
   input logic [STA_W-1:0] station_addr,
   input logic [MC_W-1:0]  mcast_mask
);
   logic isr_write;
   logic imr_write;
   assign isr_write = host_wr && host_addr == 4'h7 && cmd_q[7:6] == 2'b00;
   assign imr_write = host_wr && host_addr == 4'hF && cmd_q[7:6] == 2'b00;

   // R7
   rst_bit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isr_write |=> isr_q[7] == $past(isr_q[7]));

   // R9
   start_clears_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 4'h0 && host_wdata[1]) |=> !isr_q[7]);

   // R12
   rx_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> isr_q[0]);

   // R12
   dma_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done |=> isr_q[6]);

   // R11
   tx_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> !tx_req);

   // R11
   tx_req_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> (isr_q[1] && tsr_q == 8'h01));

   // R8
   irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (imr_q == 8'h00) |-> !irq);

   // R8
   irq_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && imr_q[0] && !imr_write) |=> irq);

   // R6
   high_bank_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr != 4'h0 && cmd_q[7]) |=>
      ($stable(ring_start) && $stable(tx_count) && $stable(station_addr) && $stable(mcast_mask)));
endmodule

bind netctl_regfile netctl_regfile_chk #(
   .STA_W (8 * N_STA),
   .MC_W  (8 * N_MC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_addr    (host_addr),
   .host_wr      (host_wr),
   .host_wdata   (host_wdata),
   .rx_done      (rx_done),
   .dma_done     (dma_done),
   .irq          (irq),
   .tx_req       (tx_req),
   .cmd_q        (cmd_q),
   .isr_q        (isr_q),
   .imr_q        (imr_q),
   .tsr_q        (tsr_q),
   .ring_start   (ring_start),
   .tx_count     (tx_count),
   .station_addr (station_addr),
   .mcast_mask   (mcast_mask)
);

// File: tb/test_netctl_regfile.sv
`timescale 1ns/1ps
module test_netctl_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        rx_done = 1'b0;
   logic        dma_done = 1'b0;
   logic        irq, tx_req;
   logic [7:0]  ring_start, ring_stop, boundary, tx_page, data_cfg, cur_page;
   logic [15:0] tx_count, rdma_addr, rdma_count;
   logic [47:0] station_addr;
   logic [63:0] mcast_mask;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   netctl_regfile i_netctl_regfile (
      .clk, .rst_n, .host_addr, .host_wr, .host_wdata, .host_rdata,
      .rx_done, .dma_done, .irq, .tx_req,
      .ring_start, .ring_stop, .boundary, .tx_page, .tx_count,
      .rdma_addr, .rdma_count, .data_cfg, .cur_page,
      .station_addr, .mcast_mask
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // drive on a falling edge, return on the next falling edge
   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic pulse_rx();
      @(negedge clk); rx_done = 1'b1;
      @(negedge clk); rx_done = 1'b0;
   endtask

   task automatic pulse_dma();
      @(negedge clk); dma_done = 1'b1;
      @(negedge clk); dma_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(4'h7, v); chk("R1 isr after reset", v, 8'h80);
      rd(4'h0, v); chk("R1 cmd after reset", v, 8'h00);
      chk("R1 irq after reset", irq, 1'b0);
      chk("R1 tx_req after reset", tx_req, 1'b0);
      chk("R1 setup outputs zero", {ring_start, ring_stop, tx_count, rdma_count, station_addr}, 64'h0);
   endtask

   task automatic t_bank0();
      logic [7:0] v;
      wr(4'h1, 8'h46); wr(4'h2, 8'h80); wr(4'h3, 8'h4C); wr(4'h4, 8'h40);
      wr(4'h5, 8'h34); wr(4'h6, 8'h12); wr(4'h8, 8'h78); wr(4'h9, 8'h56);
      wr(4'hA, 8'h10); wr(4'hB, 8'h00); wr(4'hE, 8'h49);
      chk("R3 ring start/stop/boundary/tx page", {ring_start, ring_stop, boundary, tx_page}, 32'h46804C40);
      chk("R3 tx count", tx_count, 16'h1234);
      chk("R3 remote addr and count", {rdma_addr, rdma_count}, 32'h5678_0010);
      chk("R3 data config", data_cfg, 8'h49);
      wr(4'h5, 8'hAB);
      chk("R3 low half write keeps high half", tx_count, 16'h12AB);
      wr(4'h9, 8'h9A);
      chk("R3 high half write keeps low half", rdma_addr, 16'h9A78);
      rd(4'h3, v); chk("R4 boundary readback", v, 8'h4C);
      rd(4'h8, v); chk("R4 remote addr low readback", v, 8'h78);
      rd(4'h9, v); chk("R4 remote addr high readback", v, 8'h9A);
      rd(4'h4, v); chk("R4 offset 4 reads tx status", v, 8'h00);
      rd(4'h1, v); chk("R4 write-only offset reads zero", v, 8'h00);
      rd(4'hE, v); chk("R4 data config offset reads zero", v, 8'h00);
   endtask

   task automatic t_bank1();
      logic [7:0]  v;
      logic [47:0] sta_exp;
      logic [63:0] mc_exp;
      wr(4'h0, 8'h40);
      rd(4'h0, v); chk("R2 cmd readback selects bank 1", v, 8'h40);
      for (int k = 0; k < 6; k++) begin
         wr(4'(1 + k), 8'(8'h10 + k));
         sta_exp[k*8 +: 8] = 8'(8'h10 + k);
      end
      wr(4'h7, 8'h5D);
      for (int k = 0; k < 8; k++) begin
         wr(4'(8 + k), 8'(8'hA0 + k));
         mc_exp[k*8 +: 8] = 8'(8'hA0 + k);
      end
      chk("R5 station address output", station_addr, {16'h0, sta_exp});
      chk("R5 multicast mask output", mcast_mask, mc_exp);
      chk("R5 current page output", cur_page, 8'h5D);
      rd(4'h3, v); chk("R5 station byte 2 readback", v, 8'h12);
      rd(4'hF, v); chk("R5 mask byte 7 readback", v, 8'hA7);
      rd(4'h7, v); chk("R2 bank 1 offset 7 is current page", v, 8'h5D);
      chk("R2 bank 1 write left ring start", ring_start, 8'h46);
      wr(4'h0, 8'h00);
      rd(4'h7, v); chk("R2 bank 0 offset 7 is status", v, 8'h80);
   endtask

   task automatic t_bank2();
      logic [7:0] v;
      wr(4'h0, 8'h80);
      rd(4'h0, v); chk("R2 cmd readable in bank 2", v, 8'h80);
      wr(4'h1, 8'hEE); wr(4'h8, 8'hEE);
      chk("R6 bank 2 write no effect", {ring_start, rdma_addr, mcast_mask[7:0]}, 32'h469A78A0);
      rd(4'h3, v); chk("R6 bank 2 read zero", v, 8'h00);
      wr(4'h0, 8'hC0);
      wr(4'h7, 8'hEE);
      rd(4'h7, v); chk("R6 bank 3 read zero", v, 8'h00);
      wr(4'h0, 8'h00);
      chk("R6 bank 3 write no effect", {cur_page, tx_count}, 24'h5D12AB);
   endtask

   task automatic t_isr_clear();
      logic [7:0] v;
      pulse_rx();
      pulse_dma();
      rd(4'h7, v); chk("R12 rx and dma events set bits", v, 8'hC1);
      wr(4'h7, 8'h01);
      rd(4'h7, v); chk("R7 selective clear", v, 8'hC0);
      wr(4'h7, 8'hFF);
      rd(4'h7, v); chk("R7 bit 7 survives clear", v, 8'h80);
   endtask

   task automatic t_irq();
      wr(4'hF, 8'h01);
      chk("R8 irq low with no masked bit", irq, 1'b0);
      pulse_rx();
      chk("R8 irq high after masked event", irq, 1'b1);
      wr(4'hF, 8'h00);
      chk("R8 irq low after mask cleared", irq, 1'b0);
      wr(4'hF, 8'h80);
      chk("R8 irq high from reset bit", irq, 1'b1);
      wr(4'h7, 8'h01);
      wr(4'hF, 8'h00);
   endtask

   task automatic t_start();
      logic [7:0] v;
      wr(4'h0, 8'h02);
      rd(4'h7, v); chk("R9 start clears reset bit", v, 8'h00);
   endtask

   task automatic t_rdma();
      logic [7:0] v;
      wr(4'hA, 8'h10);
      wr(4'h0, 8'h0A);
      rd(4'h7, v); chk("R10 nonzero count no completion", v, 8'h00);
      wr(4'hA, 8'h00);
      wr(4'h0, 8'h12);
      rd(4'h7, v); chk("R10 zero count completes at once", v, 8'h40);
      wr(4'h7, 8'h40);
      wr(4'h0, 8'h10);
      rd(4'h7, v); chk("R10 no completion without start", v, 8'h00);
   endtask

   task automatic t_tx();
      logic [7:0] v;
      wr(4'h0, 8'h04);
      chk("R11 transmit without start no request", tx_req, 1'b0);
      rd(4'h4, v); chk("R11 tx status unchanged without start", v, 8'h00);
      wr(4'h0, 8'h06);
      chk("R11 tx_req raised", tx_req, 1'b1);
      @(negedge clk);
      chk("R11 tx_req single cycle", tx_req, 1'b0);
      rd(4'h4, v); chk("R11 tx status loaded", v, 8'h01);
      rd(4'h7, v); chk("R11 status tx bit set", v, 8'h02);
      wr(4'h7, 8'h02);
   endtask

   task automatic t_race();
      logic [7:0] v;
      pulse_rx();
      @(negedge clk);
      host_addr = 4'h7; host_wdata = 8'hFF; host_wr = 1'b1; dma_done = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; dma_done = 1'b0;
      rd(4'h7, v); chk("R12 event wins over same-cycle clear", v, 8'h40);
      @(negedge clk);
      host_addr = 4'h7; host_wdata = 8'h01; host_wr = 1'b1; rx_done = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; rx_done = 1'b0;
      rd(4'h7, v); chk("R12 rx event wins over clear", v, 8'h41);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bank0();
      t_bank1();
      t_bank2();
      t_isr_clear();
      t_irq();
      t_start();
      t_rdma();
      t_tx();
      t_race();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule